// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a small pool of waiting operations for one class of execution unit in an out-of-order core. The issue stage hands it an operation code, a destination tag and two source operands. Each operand arrives either as a finished value or as the tag of the operation that will produce it. A tag of zero means the value is already present, or that the operand is not needed. Waiting entries watch a shared result broadcast bus. When the broadcast tag matches one of their operand tags, they copy the value and clear that tag.

Each cycle the array sends at most one operation to the execution unit. It picks the lowest-indexed entry whose two operands both hold values. A dispatched entry stays allocated until a broadcast carries its own destination tag, and is then freed. A flush input clears the whole pool, for example after a mispredicted branch.

Top module: `tag_match_rs`

## Requirements
- R1: After reset every entry is free, so `issueFull` is 0 and `dispValid` is 0.
- R2: An issue with `issueValid`=1 is accepted only while `issueFull`=0, and goes into the lowest-indexed free entry. `issueFull` is 1 exactly when all entries are allocated. An issue offered while full is dropped and never dispatches.
- R3: An operand tag of 0 marks the operand as holding its value. The destination tag of an accepted issue is never 0.
- R4: A broadcast (`cdbValid`=1) whose tag equals a nonzero operand tag of a waiting entry writes `cdbValue` into that operand and clears its tag. Every matching entry and operand captures in the same cycle. The entry can dispatch from the next cycle on.
- R5: When the broadcast arrives in the same cycle as the issue that carries the matching operand tag, the value is captured at issue and the wakeup is not lost.
- R6: `dispValid` is 1 in the same cycle as an allocated, not yet dispatched entry with both operand tags at 0 exists. `dispOp`, `dispValJ`, `dispValK` and `dispDest` then carry that entry's fields. Each entry dispatches only once.
- R7: When several entries are ready, the lowest-indexed one dispatches first, and only one dispatches per cycle.
- R8: A dispatched entry becomes free in the cycle after a broadcast whose tag equals its destination tag.
- R9: In a cycle with `flush`=1, no operation dispatches and any issue is ignored. From the next cycle on all entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | 4 | Operation code |
| issueTagJ | input | 4 | Producer tag of first operand, 0 when the value is present |
| issueValJ | input | 16 | First operand value |
| issueTagK | input | 4 | Producer tag of second operand, 0 when the value is present |
| issueValK | input | 16 | Second operand value |
| issueDest | input | 4 | Destination tag (nonzero) |
| issueFull | output | 1 | All entries allocated; an issue would stall |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | 4 | Tag of the broadcast result |
| cdbValue | input | 16 | Broadcast result value |
| flush | input | 1 | Clear all entries |
| dispValid | output | 1 | An operation is dispatched this cycle |
| dispOp | output | 4 | Dispatched operation code |
| dispValJ | output | 16 | Dispatched first operand |
| dispValK | output | 16 | Dispatched second operand |
| dispDest | output | 4 | Dispatched destination tag |

## Verification
The risky overlap is an issue and a broadcast in the same cycle, where the broadcast tag equals a tag the incoming operand is waiting on. The bench forces this in a directed step, and it also arises often in random traffic because producer tags, destination tags and broadcast tags all come from one small pool of seven values. A lost wakeup would leave the entry waiting forever, so a bench reference model predicts every dispatch cycle and payload, and any mismatch is caught. Broadcasts that capture operands and free a dispatched entry at the same time are judged by the same model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_DEPTH  = 4;
  parameter int RS_OP_W   = 4;
  parameter int RS_DATA_W = 16;
  parameter int RS_TAG_W  = 4;

  typedef logic [RS_DEPTH-1:0] slotVec_t;

  // strobes from control to datapath
  typedef struct packed {
    slotVec_t allocOh;
    slotVec_t dispOh;
    logic     flushAll;
  } rsStrobe_t;

  function automatic slotVec_t lowestSet(slotVec_t v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       flush,
  input  slotVec_t   freeVec,
  input  slotVec_t   readyVec,
  output rsStrobe_t  strobe,
  output logic       issueFull,
  output logic       dispValid
);
  always_comb begin
    issueFull       = ~|freeVec;
    strobe.flushAll = flush;
    strobe.allocOh  = (issueValid && !flush) ? lowestSet(freeVec) : '0;
    strobe.dispOh   = flush ? '0 : lowestSet(readyVec);
    dispValid       = |strobe.dispOh;
  end

  assert_single_dispatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.dispOh));
  assert_single_alloc_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.allocOh));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rsStrobe_t            strobe,
  input  logic [RS_OP_W-1:0]   issueOp,
  input  logic [RS_TAG_W-1:0]  issueTagJ,
  input  logic [RS_DATA_W-1:0] issueValJ,
  input  logic [RS_TAG_W-1:0]  issueTagK,
  input  logic [RS_DATA_W-1:0] issueValK,
  input  logic [RS_TAG_W-1:0]  issueDest,
  input  logic                 cdbValid,
  input  logic [RS_TAG_W-1:0]  cdbTag,
  input  logic [RS_DATA_W-1:0] cdbValue,
  output slotVec_t             freeVec,
  output slotVec_t             readyVec,
  output logic [RS_OP_W-1:0]   dispOp,
  output logic [RS_DATA_W-1:0] dispValJ,
  output logic [RS_DATA_W-1:0] dispValK,
  output logic [RS_TAG_W-1:0]  dispDest
);
  slotVec_t             busy;
  slotVec_t             launched;
  logic [RS_OP_W-1:0]   opQ   [RS_DEPTH];
  logic [RS_TAG_W-1:0]  tagJ  [RS_DEPTH];
  logic [RS_TAG_W-1:0]  tagK  [RS_DEPTH];
  logic [RS_DATA_W-1:0] valJ  [RS_DEPTH];
  logic [RS_DATA_W-1:0] valK  [RS_DEPTH];
  logic [RS_TAG_W-1:0]  destQ [RS_DEPTH];

  logic hitJIn, hitKIn;
  assign hitJIn = cdbValid && (issueTagJ != '0) && (cdbTag == issueTagJ);
  assign hitKIn = cdbValid && (issueTagK != '0) && (cdbTag == issueTagK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= '0;
      launched <= '0;
      for (int i = 0; i < RS_DEPTH; i++) begin
        opQ[i]   <= '0;
        tagJ[i]  <= '0;
        tagK[i]  <= '0;
        valJ[i]  <= '0;
        valK[i]  <= '0;
        destQ[i] <= '0;
      end
    end else if (strobe.flushAll) begin
      busy     <= '0;
      launched <= '0;
    end else begin
      for (int i = 0; i < RS_DEPTH; i++) begin
        if (strobe.allocOh[i]) begin
          busy[i]     <= 1'b1;
          launched[i] <= 1'b0;
          opQ[i]      <= issueOp;
          destQ[i]    <= issueDest;
          tagJ[i]     <= hitJIn ? '0 : issueTagJ;
          valJ[i]     <= hitJIn ? cdbValue : issueValJ;
          tagK[i]     <= hitKIn ? '0 : issueTagK;
          valK[i]     <= hitKIn ? cdbValue : issueValK;
        end else if (busy[i]) begin
          if (launched[i] && cdbValid && (cdbTag == destQ[i])) begin
            busy[i]     <= 1'b0;
            launched[i] <= 1'b0;
          end else begin
            if (strobe.dispOh[i]) launched[i] <= 1'b1;
            if (!launched[i] && cdbValid && (tagJ[i] != '0) && (cdbTag == tagJ[i])) begin
              tagJ[i] <= '0;
              valJ[i] <= cdbValue;
            end
            if (!launched[i] && cdbValid && (tagK[i] != '0) && (cdbTag == tagK[i])) begin
              tagK[i] <= '0;
              valK[i] <= cdbValue;
            end
          end
        end
      end
    end
  end

  always_comb begin
    dispOp   = '0;
    dispValJ = '0;
    dispValK = '0;
    dispDest = '0;
    for (int i = 0; i < RS_DEPTH; i++) begin
      freeVec[i]  = !busy[i];
      readyVec[i] = busy[i] && !launched[i] && (tagJ[i] == '0) && (tagK[i] == '0);
      if (strobe.dispOh[i]) begin
        dispOp   = dispOp   | opQ[i];
        dispValJ = dispValJ | valJ[i];
        dispValK = dispValK | valK[i];
        dispDest = dispDest | destQ[i];
      end
    end
  end

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (busy == '0));
  assert_nonzero_dest_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.allocOh != '0) |-> (issueDest != '0));

  for (genvar g = 0; g < RS_DEPTH; g++) begin : gChk
    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.allocOh[g] |-> !busy[g]);
    assert_dispatch_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.dispOh[g] |-> (busy[g] && !launched[g] && tagJ[g] == '0 && tagK[g] == '0));
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busy[g] && !launched[g] && !strobe.flushAll && cdbValid && tagJ[g] != '0 && cdbTag == tagJ[g])
      |=> (tagJ[g] == '0 && valJ[g] == $past(cdbValue)));
    assert_issue_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.allocOh[g] && hitKIn) |=> (tagK[g] == '0));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
      (launched[g] && cdbValid && cdbTag == destQ[g]) |=> !busy[g]);
  end
endmodule

// File: rtl/tag_match_rs.sv
module tag_match_rs
  import rs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [RS_OP_W-1:0]   issueOp,
  input  logic [RS_TAG_W-1:0]  issueTagJ,
  input  logic [RS_DATA_W-1:0] issueValJ,
  input  logic [RS_TAG_W-1:0]  issueTagK,
  input  logic [RS_DATA_W-1:0] issueValK,
  input  logic [RS_TAG_W-1:0]  issueDest,
  output logic                 issueFull,
  input  logic                 cdbValid,
  input  logic [RS_TAG_W-1:0]  cdbTag,
  input  logic [RS_DATA_W-1:0] cdbValue,
  input  logic                 flush,
  output logic                 dispValid,
  output logic [RS_OP_W-1:0]   dispOp,
  output logic [RS_DATA_W-1:0] dispValJ,
  output logic [RS_DATA_W-1:0] dispValK,
  output logic [RS_TAG_W-1:0]  dispDest
);
  rsStrobe_t strobe;
  slotVec_t  freeVec;
  slotVec_t  readyVec;

  rs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .flush(flush),
    .freeVec(freeVec), .readyVec(readyVec), .strobe(strobe),
    .issueFull(issueFull), .dispValid(dispValid)
  );

  rs_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueOp(issueOp), .issueTagJ(issueTagJ), .issueValJ(issueValJ),
    .issueTagK(issueTagK), .issueValK(issueValK), .issueDest(issueDest),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue),
    .freeVec(freeVec), .readyVec(readyVec),
    .dispOp(dispOp), .dispValJ(dispValJ), .dispValK(dispValK), .dispDest(dispDest)
  );
endmodule

// File: tb/sim_tag_match_rs.sv
module sim_tag_match_rs;
  import rs_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, cdbValid = 1'b0, flush = 1'b0;
  logic [RS_OP_W-1:0]   issueOp = '0;
  logic [RS_TAG_W-1:0]  issueTagJ = '0, issueTagK = '0, issueDest = '0, cdbTag = '0;
  logic [RS_DATA_W-1:0] issueValJ = '0, issueValK = '0, cdbValue = '0;
  logic issueFull, dispValid;
  logic [RS_OP_W-1:0]   dispOp;
  logic [RS_DATA_W-1:0] dispValJ, dispValK;
  logic [RS_TAG_W-1:0]  dispDest;

  always #10 clk = ~clk;

  tag_match_rs u0 (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model state
  bit                   mBusy [RS_DEPTH];
  bit                   mLaunch [RS_DEPTH];
  logic [RS_OP_W-1:0]   mOp [RS_DEPTH];
  logic [RS_TAG_W-1:0]  mTJ [RS_DEPTH], mTK [RS_DEPTH], mDest [RS_DEPTH];
  logic [RS_DATA_W-1:0] mVJ [RS_DEPTH], mVK [RS_DEPTH];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit modelFull();
    for (int i = 0; i < RS_DEPTH; i++) if (!mBusy[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int modelDisp();
    if (flush) return -1;
    for (int i = 0; i < RS_DEPTH; i++)
      if (mBusy[i] && !mLaunch[i] && mTJ[i] == 0 && mTK[i] == 0) return i;
    return -1;
  endfunction

  // called just after a falling edge with inputs set; compares, advances model, waits next falling edge
  task automatic cyc(string req);
    int  di;
    int  ai;
    bit  full;
    #2;
    full = modelFull();
    di = modelDisp();
    check(issueFull == full, req, 64'(issueFull), 64'(full));
    check(dispValid == (di >= 0), req, 64'(dispValid), 64'(di >= 0));
    if (di >= 0 && dispValid)
      check({dispOp, dispValJ, dispValK, dispDest} == {mOp[di], mVJ[di], mVK[di], mDest[di]}, req,
            64'({dispOp, dispValJ, dispValK, dispDest}), 64'({mOp[di], mVJ[di], mVK[di], mDest[di]}));
    if (flush) begin
      for (int i = 0; i < RS_DEPTH; i++) begin mBusy[i] = 0; mLaunch[i] = 0; end
    end else begin
      ai = -1;
      if (issueValid && !full)
        for (int i = RS_DEPTH - 1; i >= 0; i--) if (!mBusy[i]) ai = i;
      for (int i = 0; i < RS_DEPTH; i++) begin
        if (mBusy[i]) begin
          if (mLaunch[i] && cdbValid && cdbTag == mDest[i]) begin
            mBusy[i] = 0; mLaunch[i] = 0;
          end else if (!mLaunch[i]) begin
            if (i == di) mLaunch[i] = 1;
            if (cdbValid && mTJ[i] != 0 && cdbTag == mTJ[i]) begin mTJ[i] = 0; mVJ[i] = cdbValue; end
            if (cdbValid && mTK[i] != 0 && cdbTag == mTK[i]) begin mTK[i] = 0; mVK[i] = cdbValue; end
          end
        end
      end
      if (ai >= 0) begin
        mBusy[ai] = 1; mLaunch[ai] = 0; mOp[ai] = issueOp; mDest[ai] = issueDest;
        if (cdbValid && issueTagJ != 0 && cdbTag == issueTagJ) begin mTJ[ai] = 0; mVJ[ai] = cdbValue; end
        else begin mTJ[ai] = issueTagJ; mVJ[ai] = issueValJ; end
        if (cdbValid && issueTagK != 0 && cdbTag == issueTagK) begin mTK[ai] = 0; mVK[ai] = cdbValue; end
        else begin mTK[ai] = issueTagK; mVK[ai] = issueValK; end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    issueValid = 0; cdbValid = 0; flush = 0;
  endtask

  task automatic iss(logic [3:0] op, logic [3:0] tj, logic [15:0] vj,
                     logic [3:0] tk, logic [15:0] vk, logic [3:0] dst);
    issueValid = 1; issueOp = op; issueTagJ = tj; issueValJ = vj;
    issueTagK = tk; issueValK = vk; issueDest = dst;
  endtask

  task automatic bcast(logic [3:0] t, logic [15:0] v);
    cdbValid = 1; cdbTag = t; cdbValue = v;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < RS_DEPTH; i++) begin
      mBusy[i] = 0; mLaunch[i] = 0; mOp[i] = 0; mTJ[i] = 0; mTK[i] = 0;
      mDest[i] = 0; mVJ[i] = 0; mVK[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    idle(); cyc("R1");
    // R6: ready operands dispatch next cycle, only once
    iss(4'h1, 0, 16'h0011, 0, 16'h0022, 4'd3); cyc("R6");
    idle(); cyc("R6"); cyc("R6");
    // R8: broadcast of own destination frees entry
    bcast(4'd3, 16'h0abc); cyc("R8");
    idle(); cyc("R8");
    // R4: two entries waiting on tag 5 wake together; R7 lowest first
    iss(4'h2, 4'd5, 0, 0, 16'h0033, 4'd4); cyc("R4");
    iss(4'h3, 4'd5, 0, 4'd5, 0, 4'd6); cyc("R4");
    idle(); bcast(4'd5, 16'h0055); cyc("R4");
    idle(); cyc("R7"); cyc("R7");
    bcast(4'd4, 16'h0001); cyc("R8");
    bcast(4'd6, 16'h0002); cyc("R8");
    idle(); cyc("R8");
    // R5: broadcast in the issue cycle
    iss(4'h4, 4'd2, 0, 0, 16'h0009, 4'd7); bcast(4'd2, 16'h0077); cyc("R5");
    idle(); cyc("R5");
    bcast(4'd7, 16'h0003); cyc("R5");
    idle(); cyc("R5");
    // R2: fill, then an extra issue while full is dropped
    for (int i = 0; i < RS_DEPTH; i++) begin
      iss(4'(8 + i), 4'd1, 0, 0, 16'(i), 4'd2); cyc("R2");
    end
    iss(4'hf, 0, 16'hdead, 0, 16'hbeef, 4'd5); cyc("R2");
    idle(); cyc("R2"); cyc("R2");
    // R9: wake all, then flush with a ready entry and a pending issue
    bcast(4'd1, 16'h1234); cyc("R4");
    idle(); flush = 1; iss(4'h1, 0, 1, 0, 2, 4'd3); cyc("R9");
    idle(); cyc("R9"); cyc("R9");
    // R7: constrained random traffic against the model
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      issueValid = ($urandom % 2) == 0;
      issueOp    = 4'($urandom);
      issueTagJ  = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 7);
      issueTagK  = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 7);
      issueValJ  = 16'($urandom);
      issueValK  = 16'($urandom);
      issueDest  = 4'(1 + $urandom % 7);
      cdbValid   = ($urandom % 3) != 0;
      cdbTag     = 4'(1 + $urandom % 7);
      cdbValue   = 16'($urandom);
      flush      = ($urandom % 100) == 0;
      cyc("R7");
    end
    idle(); cyc("R7");
    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end
endmodule